// File: doc/BRIEF.md
# Page Translation Buffer with Rights Check

This block is a small, fully associative translation buffer for a flat 32-bit, byte-addressed virtual space with 4 KB pages. Each lookup presents a virtual address, an access kind (read or write), a privilege level (user or supervisor) and the current task number. One clock later the block returns either a physical address or a single fault code. The fault codes are miss, page not present, and rights violation.

Software fills the buffer through a write port that carries a virtual page number, a task number, a physical page number, a present flag and a 2-bit rights code. A separate strobe clears every entry at once. The top quarter of the address space (virtual address bits 31:30 equal to 3) is common to all tasks, so the task number takes no part in matching there. Below that quarter, an entry matches only the task that loaded it.

Top module: `page_xlate_buf`

## Requirements
- R1: A synchronous active-high reset leaves every entry invalid and sets `rsp_valid`, `rsp_fault` and `rsp_paddr` to zero. A lookup made after reset reports a miss.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. The result reflects the table as it stood at that lookup's clock edge, so a load in the same cycle is not yet visible to it.
- R3: On a lookup with no fault, `rsp_paddr` equals the entry's 20-bit physical page number concatenated with `lk_vaddr[11:0]`. On any fault, `rsp_paddr` is zero.
- R4: An entry matches when its virtual page number equals `lk_vaddr[31:12]` and its task number equals `lk_task`. When `lk_vaddr[31:30]` is 3, the task number is ignored. Pages below that region with the same page number but different tasks are separate entries.
- R5: `rsp_fault` is coded as follows: 0 for none, 1 for miss, 2 for not present, and 3 for rights violation. Only one code is reported. Miss takes priority over not present, and not present takes priority over a rights violation.
- R6: For user accesses, rights code 0 faults on any access and code 1 faults on writes only. Codes 2 and 3 allow both reads and writes.
- R7: A supervisor access never reports a rights violation, whatever the rights code.
- R8: Loads of new pages fill entries in round-robin order, starting at entry 0 after reset or a clear. With 8 entries, the ninth new page evicts the first one loaded.
- R9: A load whose page number matches a valid entry replaces that entry in place and does not advance the round-robin pointer. The task number takes part in this match except in region 3.
- R10: `inv_all` invalidates every entry in one cycle and returns the round-robin pointer to entry 0. It takes priority over a load in the same cycle, so that load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual byte address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_super | input | 1 | 1 = supervisor, 0 = user |
| lk_task | input | 4 | Current task number |
| wr_en | input | 1 | Load one entry |
| wr_vpn | input | 20 | Virtual page number to load |
| wr_task | input | 4 | Task number of the loaded entry |
| wr_ppn | input | 20 | Physical page number |
| wr_present | input | 1 | Present flag of the loaded entry |
| wr_rights | input | 2 | Rights code of the loaded entry |
| inv_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | Fault code (see R5) |

## Verification
The assertions assume that `lk_valid`, `inv_all` and the load inputs are driven to known values in every cycle once reset is released. They also assume that a clear is followed by a lookup only when the same cycle carries no load that could refill an entry before that lookup samples the table. The directed stimulus changes inputs only on the falling clock edge and holds them steady for one full cycle. It never loads a page in the cycle between a clear and the lookup that checks the clear.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_NP   = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  localparam logic [1:0] RGT_NO_USER = 2'd0;
  localparam logic [1:0] RGT_RO      = 2'd1;
  localparam logic [1:0] RGT_RW      = 2'd2;
  localparam logic [1:0] RGT_FULL    = 2'd3;

  localparam logic [1:0] SHARED_REGION = 2'b11;

endpackage

// File: rtl/pxb_tag_store.sv
module pxb_tag_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int TASK_W  = 4,
  parameter int PPN_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [TASK_W-1:0] lk_task,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [TASK_W-1:0] wr_task,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_present,
  input  logic [1:0]        wr_rights,
  input  logic              inv_all,
  output logic              hit,
  output logic [PPN_W-1:0]  hit_ppn,
  output logic              hit_present,
  output logic [1:0]        hit_rights
);
  import pxb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q     [ENTRIES];
  logic [TASK_W-1:0]  task_q    [ENTRIES];
  logic [PPN_W-1:0]   ppn_q     [ENTRIES];
  logic               present_q [ENTRIES];
  logic [1:0]         rights_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] wr_match;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_reuse;

  wire lk_shared = (lk_vpn[VPN_W-1 -: 2] == SHARED_REGION);
  wire wr_shared = (wr_vpn[VPN_W-1 -: 2] == SHARED_REGION);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) &&
                         (lk_shared || (task_q[g] == lk_task));
    assign wr_match[g] = valid_q[g] && (vpn_q[g] == wr_vpn) &&
                         (wr_shared || (task_q[g] == wr_task));
  end

  always_comb begin
    hit         = |lk_match;
    hit_ppn     = '0;
    hit_present = 1'b0;
    hit_rights  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        hit_ppn     = hit_ppn | ppn_q[i];
        hit_present = hit_present | present_q[i];
        hit_rights  = hit_rights | rights_q[i];
      end
    end
  end

  always_comb begin
    wr_reuse = |wr_match;
    wr_idx   = rr_ptr;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (wr_match[i]) wr_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      rr_ptr <= '0;
    end else if (wr_en && !wr_reuse) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all && !rst) begin
      vpn_q[wr_idx]     <= wr_vpn;
      task_q[wr_idx]    <= wr_task;
      ppn_q[wr_idx]     <= wr_ppn;
      present_q[wr_idx] <= wr_present;
      rights_q[wr_idx]  <= wr_rights;
    end
  end

endmodule

// File: rtl/pxb_rights.sv
module pxb_rights (
  input  logic [1:0] rights,
  input  logic       is_write,
  input  logic       is_super,
  output logic       violation
);
  import pxb_pkg::*;

  always_comb begin
    violation = 1'b0;
    if (!is_super) begin
      case (rights)
        RGT_NO_USER: violation = 1'b1;
        RGT_RO:      violation = is_write;
        default:     violation = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/page_xlate_buf.sv
module page_xlate_buf #(
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int TASK_W  = 4,
  parameter int ENTRIES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic                lk_write,
  input  logic                lk_super,
  input  logic [TASK_W-1:0]   lk_task,
  input  logic                wr_en,
  input  logic [VA_W-PAGE_W-1:0] wr_vpn,
  input  logic [TASK_W-1:0]   wr_task,
  input  logic [VA_W-PAGE_W-1:0] wr_ppn,
  input  logic                wr_present,
  input  logic [1:0]          wr_rights,
  input  logic                inv_all,
  output logic                rsp_valid,
  output logic [VA_W-1:0]     rsp_paddr,
  output logic [1:0]          rsp_fault
);
  import pxb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_W;

  logic             hit;
  logic [VPN_W-1:0] hit_ppn;
  logic             hit_present;
  logic [1:0]       hit_rights;
  logic             rights_bad;
  fault_e           fault_d;

  pxb_tag_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .TASK_W(TASK_W), .PPN_W(VPN_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .lk_vpn(lk_vaddr[VA_W-1:PAGE_W]), .lk_task(lk_task),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_task(wr_task), .wr_ppn(wr_ppn),
    .wr_present(wr_present), .wr_rights(wr_rights), .inv_all(inv_all),
    .hit(hit), .hit_ppn(hit_ppn), .hit_present(hit_present),
    .hit_rights(hit_rights)
  );

  pxb_rights u_rights (
    .rights(hit_rights), .is_write(lk_write), .is_super(lk_super),
    .violation(rights_bad)
  );

  always_comb begin
    if (!hit)              fault_d = FLT_MISS;
    else if (!hit_present) fault_d = FLT_NP;
    else if (rights_bad)   fault_d = FLT_PROT;
    else                   fault_d = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_fault <= fault_d;
        rsp_paddr <= (fault_d == FLT_NONE) ? {hit_ppn, lk_vaddr[PAGE_W-1:0]} : '0;
      end
    end
  end

endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_super,
  input logic            inv_all,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);
  import pxb_pkg::*;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rsp_valid); // R1

  AST_RSP_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid); // R2

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rsp_fault != FLT_NONE) ||
                 (rsp_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0]))); // R3

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0)); // R3

  AST_SUPER_NO_PROT: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_super) |=> (rsp_fault != FLT_PROT)); // R7

  AST_CLEAR_MISS: assert property (@(posedge clk) disable iff (rst)
    inv_all ##1 lk_valid |=> (rsp_fault == FLT_MISS)); // R10

endmodule

bind page_xlate_buf pxb_checker #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_super(lk_super), .inv_all(inv_all), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/page_xlate_buf_tb.sv
module page_xlate_buf_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_super = 1'b0;
  logic [3:0]  lk_task = '0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_vpn = '0;
  logic [3:0]  wr_task = '0;
  logic [19:0] wr_ppn = '0;
  logic        wr_present = 1'b0;
  logic [1:0]  wr_rights = '0;
  logic        inv_all = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [1:0] F_OK = 2'd0, F_MISS = 2'd1, F_NP = 2'd2, F_PROT = 2'd3;

  always #10 clk = ~clk;

  page_xlate_buf u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_super(lk_super), .lk_task(lk_task),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_task(wr_task), .wr_ppn(wr_ppn),
    .wr_present(wr_present), .wr_rights(wr_rights), .inv_all(inv_all),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [19:0] vpn, input logic [3:0] tsk,
                      input logic [19:0] ppn, input logic pres, input logic [1:0] rg);
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = vpn; wr_task = tsk; wr_ppn = ppn;
    wr_present = pres; wr_rights = rg;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic [3:0] tsk,
                        input logic wr, input logic sup,
                        input logic [1:0] exp_f, input logic [31:0] exp_pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_task = tsk; lk_write = wr; lk_super = sup;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
    check({req, " paddr"}, rsp_paddr, exp_pa);
  endtask

  task automatic t_reset();
    check("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 reset fault", {30'd0, rsp_fault}, 32'd0);
    check("R1 reset paddr", rsp_paddr, 32'd0);
    lookup("R1 miss after reset", 32'h0000_1234, 4'd0, 1'b0, 1'b0, F_MISS, 32'd0);
  endtask

  task automatic t_timing();
    clear_all();
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = 20'h00abc; wr_task = 4'd1; wr_ppn = 20'h12345;
    wr_present = 1'b1; wr_rights = 2'd2;
    lk_valid = 1'b1; lk_vaddr = 32'h00ab_c010; lk_task = 4'd1;
    lk_write = 1'b0; lk_super = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    check("R2 same-cycle load unseen", {30'd0, rsp_fault}, {30'd0, F_MISS});
    @(negedge clk);
    check("R2 valid drops", {31'd0, rsp_valid}, 32'd0);
    lookup("R2 R3 hit next", 32'h00ab_cfed, 4'd1, 1'b0, 1'b0, F_OK, 32'h1234_5fed);
  endtask

  task automatic t_tasks();
    clear_all();
    load(20'h00456, 4'd5, 20'h0aaaa, 1'b1, 2'd3);
    load(20'h00456, 4'd6, 20'h0bbbb, 1'b1, 2'd3);
    load(20'hc0123, 4'd5, 20'h0cccc, 1'b1, 2'd3);
    lookup("R4 task5", 32'h0045_6001, 4'd5, 1'b0, 1'b0, F_OK, 32'h0aaa_a001);
    lookup("R4 task6", 32'h0045_6002, 4'd6, 1'b0, 1'b0, F_OK, 32'h0bbb_b002);
    lookup("R4 task9 miss", 32'h0045_6003, 4'd9, 1'b0, 1'b0, F_MISS, 32'd0);
    lookup("R4 shared other task", 32'hc012_3004, 4'd9, 1'b1, 1'b0, F_OK, 32'h0ccc_c004);
  endtask

  task automatic t_rights();
    clear_all();
    load(20'h00010, 4'd2, 20'h00100, 1'b1, 2'd0);
    load(20'h00011, 4'd2, 20'h00101, 1'b1, 2'd1);
    load(20'h00012, 4'd2, 20'h00102, 1'b1, 2'd2);
    load(20'h00013, 4'd2, 20'h00103, 1'b1, 2'd3);
    load(20'h00014, 4'd2, 20'h00104, 1'b0, 2'd0);
    lookup("R6 nouser read",  32'h0001_0000, 4'd2, 1'b0, 1'b0, F_PROT, 32'd0);
    lookup("R6 ro read",      32'h0001_1008, 4'd2, 1'b0, 1'b0, F_OK, 32'h0010_1008);
    lookup("R6 ro write",     32'h0001_1008, 4'd2, 1'b1, 1'b0, F_PROT, 32'd0);
    lookup("R6 rw write",     32'h0001_200c, 4'd2, 1'b1, 1'b0, F_OK, 32'h0010_200c);
    lookup("R6 full write",   32'h0001_3fff, 4'd2, 1'b1, 1'b0, F_OK, 32'h0010_3fff);
    lookup("R7 super nouser write", 32'h0001_0abc, 4'd2, 1'b1, 1'b1, F_OK, 32'h0010_0abc);
    lookup("R7 super ro write",     32'h0001_1abc, 4'd2, 1'b1, 1'b1, F_OK, 32'h0010_1abc);
    lookup("R5 np over prot", 32'h0001_4000, 4'd2, 1'b1, 1'b0, F_NP, 32'd0);
    lookup("R5 miss first",   32'h0001_5000, 4'd2, 1'b1, 1'b0, F_MISS, 32'd0);
  endtask

  task automatic t_round_robin();
    load(20'h00777, 4'd0, 20'h00777, 1'b1, 2'd2);
    load(20'h00778, 4'd0, 20'h00778, 1'b1, 2'd2);
    clear_all();
    for (int i = 0; i < 9; i++) load(20'h00200 + 20'(i), 4'd3, 20'h05000 + 20'(i), 1'b1, 2'd2);
    lookup("R8 R10 first evicted", 32'h0020_0000, 4'd3, 1'b0, 1'b0, F_MISS, 32'd0);
    lookup("R8 second kept", 32'h0020_1010, 4'd3, 1'b0, 1'b0, F_OK, 32'h0500_1010);
    lookup("R8 ninth kept",  32'h0020_8020, 4'd3, 1'b0, 1'b0, F_OK, 32'h0500_8020);
  endtask

  task automatic t_reuse();
    clear_all();
    load(20'h00300, 4'd4, 20'h01111, 1'b1, 2'd2);
    load(20'h00300, 4'd4, 20'h02222, 1'b1, 2'd2);
    lookup("R9 overwritten", 32'h0030_0044, 4'd4, 1'b0, 1'b0, F_OK, 32'h0222_2044);
    for (int i = 1; i < 8; i++) load(20'h00400 + 20'(i), 4'd4, 20'h03000 + 20'(i), 1'b1, 2'd2);
    lookup("R9 pointer held", 32'h0030_0048, 4'd4, 1'b0, 1'b0, F_OK, 32'h0222_2048);
    load(20'h00500, 4'd4, 20'h04444, 1'b1, 2'd2);
    lookup("R9 evicted on wrap", 32'h0030_0048, 4'd4, 1'b0, 1'b0, F_MISS, 32'd0);
    lookup("R9 neighbour kept", 32'h0040_1000, 4'd4, 1'b0, 1'b0, F_OK, 32'h0300_1000);
  endtask

  task automatic t_clear_priority();
    @(negedge clk);
    inv_all = 1'b1; wr_en = 1'b1; wr_vpn = 20'h00600; wr_task = 4'd1;
    wr_ppn = 20'h06666; wr_present = 1'b1; wr_rights = 2'd2;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    lookup("R10 load dropped", 32'h0060_0000, 4'd1, 1'b0, 1'b0, F_MISS, 32'd0);
    lookup("R10 all cleared",  32'h0040_1000, 4'd4, 1'b0, 1'b0, F_MISS, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timing();
    t_tasks();
    t_rights();
    t_round_robin();
    t_reuse();
    t_clear_priority();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule